// File: doc/BRIEF.md
# Multi-Packet Beat Splitter and Lane-0 Aligner

This block sits on a wide AXI-Stream path. Its input side may pack more than one packet into one beat: a packet can begin in the segment that follows the one where the previous packet finished. Its output side presents at most one packet per beat, and every packet starts at byte lane 0 of its first output beat. Downstream logic, such as a header filter, can then read protocol fields at fixed bit positions in the start-of-packet beat.

The input bus is cut into equal segments. Each segment has its own start flag, end flag and unused-byte count. The block keeps track of where the current packet began within its first input beat. It rotates the bus so that byte sits on lane 0, and it stitches each output beat together from a carry register and the next input beat. It works out the output byte enables and the last marker from the end segment and its unused-byte count. While it splits a beat that holds two packets, it holds input ready low.

Top module: `pkt_lane_aligner`

## Requirements
- R1: After reset, with no input valid, `m_valid` and `s_ready` are low.
- R2: A packet that begins in segment 0 is output byte for byte, 64 bytes per beat. Packet byte n of each beat sits on lane n mod 64, where lane b is `m_data[8b+7:8b]`. Segment i is `s_data[64i+63:64i]`, and packet bytes fill ascending lanes.
- R3: A packet that begins in segment s > 0 of its first input beat appears with its first byte on lane 0. Later output beats carry the following 64 packet bytes, stitched from the tail of one input beat and the head of the next.
- R4: If one input beat holds the end of packet A and the start of packet B, two output beats come out: first the end of A, then B from lane 0. With `m_ready` high, `s_ready` is low in the first of those cycles and high in the second.
- R5: On every valid output beat, `m_keep` is a contiguous run of ones starting at lane 0. It is all ones on a beat without `m_last`. On a last beat its count is the number of packet bytes left. In the end segment, the valid bytes are the low 8 − `s_empty[3i+2:3i]` bytes of segment i.
- R6: `m_last` is high exactly on the final output beat of each packet.
- R7: If the bytes of a packet still left after an input beat do not fit into the current output beat, the block issues one extra output beat that carries only those bytes. It does not need a new input beat to do so.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data`, `m_keep` and `m_last` hold their values into the next cycle.
- R9: An input beat is accepted only in a cycle where either no output beat is presented or the output beat is accepted.
- R10: Every output byte whose `m_keep` bit is low reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted |
| s_data | input | 512 | Input data, 8 segments of 64 bits |
| s_sop | input | 8 | Per-segment packet start flag |
| s_eop | input | 8 | Per-segment packet end flag |
| s_empty | input | 24 | Per-segment unused byte count (3 bits each), meaningful at an end segment |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Output beat accepted |
| m_data | output | 512 | Output data, packet start on lane 0 |
| m_keep | output | 64 | Output byte enables |
| m_last | output | 1 | Final beat of a packet |

## Verification
The properties assume a well-formed input stream with these features:
- Packets are contiguous in segments, with no idle segment inside a packet.
- A packet starts at a segment above 0 only directly after an end segment in the same beat.
- Each input beat stays stable until it is accepted.

The stability property also relies on that last point, because the outputs are computed from the held input beat. The stimulus builds its beats from a list of packet lengths with a packing routine that obeys these rules by construction. It holds `s_valid` and the beat until it sees `s_ready`, and it varies `m_ready` at random so that split and flush beats meet backpressure.

// File: rtl/pla_pkg.sv
// Package: shared types for the lane aligner.
// Assumes: nothing; holds only the per-cycle action encoding.
package pla_pkg;
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,  // nothing to do this cycle
        ACT_LOAD  = 2'd1,  // park the head of an offset packet in the carry
        ACT_EMIT  = 2'd2,  // present carry plus input segments
        ACT_FLUSH = 2'd3   // present the carry tail of a finished packet
    } act_e;
endpackage

// File: rtl/pla_eop_scan.sv
// Module: finds the first end-of-packet segment at or above a start index.
// Also reports whether a new packet starts in the segment right after it.
// Assumes: SEGS is a power of two and at least 2.
module pla_eop_scan #(
    parameter int SEGS = 8
) (
    input  logic [SEGS-1:0]          sop,
    input  logic [SEGS-1:0]          eop,
    input  logic [$clog2(SEGS)-1:0]  from_idx,
    output logic                     found,
    output logic [$clog2(SEGS)-1:0]  end_idx,
    output logic                     next_sop
);
    localparam int IDX_W = $clog2(SEGS);

    // Priority search from the top down so the lowest qualifying segment wins.
    always_comb begin
        found   = 1'b0;
        end_idx = '0;
        for (int i = SEGS - 1; i >= 0; i--) begin
            if (eop[i] && (IDX_W'(i) >= from_idx)) begin
                found   = 1'b1;
                end_idx = IDX_W'(i);
            end
        end
    end

    // A following packet exists only if the end is not the top segment.
    always_comb begin
        next_sop = found && (end_idx != IDX_W'(SEGS - 1)) && sop[end_idx + IDX_W'(1)];
    end
endmodule

// File: rtl/pla_seg_rotate.sv
// Module: rotates the bus by whole segments; output segment i takes input
// segment (i + amount) mod SEGS.
// Assumes: SEGS is a power of two, so the index wraps naturally.
module pla_seg_rotate #(
    parameter int SEGS  = 8,
    parameter int SEG_W = 64
) (
    input  logic [SEGS*SEG_W-1:0]    din,
    input  logic [$clog2(SEGS)-1:0]  amount,
    output logic [SEGS*SEG_W-1:0]    dout
);
    localparam int IDX_W = $clog2(SEGS);

    for (genvar i = 0; i < SEGS; i++) begin : g_seg
        logic [IDX_W-1:0] src;
        // Source segment index for this output position.
        assign src = IDX_W'(i) + amount;
        assign dout[i*SEG_W +: SEG_W] = din[src*SEG_W +: SEG_W];
    end
endmodule

// File: rtl/pla_keep_gen.sv
// Module: builds byte enables from a count of used segments and, on a last
// beat, the unused-byte count of the top used segment.
// Assumes: n_seg <= SEGS; empty < SEG_BYTES.
module pla_keep_gen #(
    parameter int SEGS      = 8,
    parameter int SEG_BYTES = 8
) (
    input  logic [$clog2(SEGS+1)-1:0]    n_seg,
    input  logic                         last,
    input  logic [$clog2(SEG_BYTES)-1:0] empty,
    output logic [SEGS*SEG_BYTES-1:0]    keep
);
    localparam int CNT_W = $clog2(SEGS + 1);
    localparam int BW    = $clog2(SEG_BYTES) + 1;

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        for (genvar j = 0; j < SEG_BYTES; j++) begin : g_byte
            // Byte is live if its segment is used and, at the packet end, below the empty span.
            assign keep[s*SEG_BYTES + j] = (CNT_W'(s) < n_seg) &&
                !(last && (CNT_W'(s) + CNT_W'(1) == n_seg) &&
                  (BW'(j) + BW'(empty) >= BW'(SEG_BYTES)));
        end
    end
endmodule

// File: rtl/pkt_lane_aligner.sv
// Module: splits multi-packet input beats and aligns every packet start to
// lane 0. A carry register keeps the segments that overflow one output beat.
// The read index picks the segment where the next packet starts inside an
// input beat that is being split.
// Assumes: packets are contiguous in segments; a start above segment 0 only
// follows an end in the same beat; the input is held until accepted.
// Outputs are combinational from state and the held input beat.
module pkt_lane_aligner #(
    parameter int SEGS      = 8,
    parameter int SEG_BYTES = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    s_valid,
    output logic                                    s_ready,
    input  logic [SEGS*SEG_BYTES*8-1:0]             s_data,
    input  logic [SEGS-1:0]                         s_sop,
    input  logic [SEGS-1:0]                         s_eop,
    input  logic [SEGS*$clog2(SEG_BYTES)-1:0]       s_empty,
    output logic                                    m_valid,
    input  logic                                    m_ready,
    output logic [SEGS*SEG_BYTES*8-1:0]             m_data,
    output logic [SEGS*SEG_BYTES-1:0]               m_keep,
    output logic                                    m_last
);
    import pla_pkg::*;

    localparam int SEG_W  = SEG_BYTES * 8;
    localparam int DATA_W = SEGS * SEG_W;
    localparam int KEEP_W = SEGS * SEG_BYTES;
    localparam int IDX_W  = $clog2(SEGS);
    localparam int CNT_W  = $clog2(SEGS + 1);
    localparam int TOT_W  = CNT_W + 1;
    localparam int EMP_W  = $clog2(SEG_BYTES);

    logic [IDX_W-1:0]  rd_idx_q;
    logic [CNT_W-1:0]  carry_cnt_q;
    logic [DATA_W-1:0] carry_q;
    logic              carry_end_q;
    logic [EMP_W-1:0]  carry_emp_q;

    logic              end_found;
    logic [IDX_W-1:0]  end_idx;
    logic              follow_sop;
    logic [CNT_W-1:0]  in_segs;
    logic [TOT_W-1:0]  total;
    logic [IDX_W-1:0]  rot_amt;
    logic [DATA_W-1:0] rotated;
    logic [DATA_W-1:0] merged;
    logic [EMP_W-1:0]  in_emp;
    logic [CNT_W-1:0]  out_segs;
    logic              out_last;
    logic [EMP_W-1:0]  out_emp;
    logic              fire;
    act_e              act;

    pla_eop_scan #(.SEGS(SEGS)) i_scan (
        .sop      (s_sop),
        .eop      (s_eop),
        .from_idx (rd_idx_q),
        .found    (end_found),
        .end_idx  (end_idx),
        .next_sop (follow_sop)
    );

    // Rotation brings segment rd_idx to carry_cnt; one of the two is always zero.
    assign rot_amt = rd_idx_q - IDX_W'(carry_cnt_q);

    pla_seg_rotate #(.SEGS(SEGS), .SEG_W(SEG_W)) i_rot (
        .din    (s_data),
        .amount (rot_amt),
        .dout   (rotated)
    );

    // Segments of the current packet available from the input beat, and the total.
    always_comb begin
        if (end_found)
            in_segs = CNT_W'(end_idx) - CNT_W'(rd_idx_q) + CNT_W'(1);
        else
            in_segs = CNT_W'(SEGS) - CNT_W'(rd_idx_q);
        total  = TOT_W'(carry_cnt_q) + TOT_W'(in_segs);
        in_emp = s_empty[end_idx*EMP_W +: EMP_W];
    end

    // Choose this cycle's action from the carry state and the input beat.
    always_comb begin
        if (carry_end_q)
            act = ACT_FLUSH;
        else if (!s_valid)
            act = ACT_IDLE;
        else if (!end_found && (total < TOT_W'(SEGS)))
            act = ACT_LOAD;
        else
            act = ACT_EMIT;
    end

    // Output beat shape: segment count, last marker and the end segment's empty count.
    always_comb begin
        out_segs = '0;
        out_last = 1'b0;
        out_emp  = '0;
        case (act)
            ACT_FLUSH: begin
                out_segs = carry_cnt_q;
                out_last = 1'b1;
                out_emp  = carry_emp_q;
            end
            ACT_EMIT: begin
                out_segs = (total > TOT_W'(SEGS)) ? CNT_W'(SEGS) : CNT_W'(total);
                out_last = end_found && (total <= TOT_W'(SEGS));
                out_emp  = in_emp;
            end
            default: ;
        endcase
    end

    for (genvar i = 0; i < SEGS; i++) begin : g_merge
        // Low segments come from the carry, the rest from the rotated input.
        assign merged[i*SEG_W +: SEG_W] = (CNT_W'(i) < carry_cnt_q) ?
                                          carry_q[i*SEG_W +: SEG_W] : rotated[i*SEG_W +: SEG_W];
    end

    pla_keep_gen #(.SEGS(SEGS), .SEG_BYTES(SEG_BYTES)) i_keep (
        .n_seg (out_segs),
        .last  (out_last),
        .empty (out_emp),
        .keep  (m_keep)
    );

    for (genvar b = 0; b < KEEP_W; b++) begin : g_mask
        // Bytes outside the enables are forced to zero.
        assign m_data[b*8 +: 8] = m_keep[b] ? merged[b*8 +: 8] : 8'h00;
    end

    assign m_valid = (act == ACT_EMIT) || (act == ACT_FLUSH);
    assign m_last  = out_last;
    assign fire    = m_valid && m_ready;
    assign s_ready = (act == ACT_LOAD) ||
                     ((act == ACT_EMIT) && m_ready && !(end_found && follow_sop));

    // Advance carry, read index and end markers on each completed action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx_q    <= '0;
            carry_cnt_q <= '0;
            carry_q     <= '0;
            carry_end_q <= 1'b0;
            carry_emp_q <= '0;
        end else begin
            case (act)
                ACT_LOAD: begin
                    carry_q     <= rotated;
                    carry_cnt_q <= CNT_W'(total);
                    rd_idx_q    <= '0;
                end
                ACT_FLUSH: begin
                    if (fire) begin
                        carry_cnt_q <= '0;
                        carry_end_q <= 1'b0;
                    end
                end
                ACT_EMIT: begin
                    if (fire) begin
                        if (total > TOT_W'(SEGS)) begin
                            carry_q     <= rotated;
                            carry_cnt_q <= CNT_W'(total - TOT_W'(SEGS));
                            carry_end_q <= end_found;
                            carry_emp_q <= in_emp;
                        end else begin
                            carry_cnt_q <= '0;
                        end
                        rd_idx_q <= (end_found && follow_sop) ? end_idx + IDX_W'(1) : '0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pla_checker.sv
// Module: protocol properties of the aligner's output and handshake.
// Assumes: the input beat is held stable while s_valid is high and s_ready low.
module pla_checker #(
    parameter int DATA_W = 512,
    parameter int KEEP_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_valid,
    input logic              s_ready,
    input logic              m_valid,
    input logic              m_ready,
    input logic [DATA_W-1:0] m_data,
    input logic [KEEP_W-1:0] m_keep,
    input logic              m_last
);
    // R5: enables start at lane 0 and have no holes.
    p_keep_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_keep[0] && ((m_keep & (m_keep + KEEP_W'(1))) == '0)));

    // R5, R6: a beat that is not last carries a full bus.
    p_full_midbeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_last) |-> (&m_keep));

    // R8: a stalled beat stays put.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_keep) && $stable(m_last)));

    // R9: no input is taken while an output beat is refused.
    p_take_only_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && m_valid) |-> m_ready);

    for (genvar b = 0; b < KEEP_W; b++) begin : g_zero
        // R10: disabled lanes read zero.
        p_dead_lane_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (m_valid && !m_keep[b]) |-> (m_data[b*8 +: 8] == 8'h00));
    end
endmodule

bind pkt_lane_aligner pla_checker #(
    .DATA_W (SEGS*SEG_BYTES*8),
    .KEEP_W (SEGS*SEG_BYTES)
) i_pla_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .m_keep  (m_keep),
    .m_last  (m_last)
);

// File: tb/test_pkt_lane_aligner.sv
// Bench: packs packets into multi-packet beats, queues the expected aligned
// beats, and a monitor compares each accepted output beat against the queue.
module test_pkt_lane_aligner;
    localparam int SEGS = 8;
    localparam int SB   = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         s_valid = 1'b0;
    logic         s_ready;
    logic [511:0] s_data = '0;
    logic [7:0]   s_sop = '0;
    logic [7:0]   s_eop = '0;
    logic [23:0]  s_empty = '0;
    logic         m_valid;
    logic         m_ready = 1'b1;
    logic [511:0] m_data;
    logic [63:0]  m_keep;
    logic         m_last;

    pkt_lane_aligner #(.SEGS(SEGS), .SEG_BYTES(SB)) i_pkt_lane_aligner (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_sop(s_sop), .s_eop(s_eop), .s_empty(s_empty),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .m_keep(m_keep), .m_last(m_last)
    );

    always #4 clk = ~clk;  // 125 MHz

    int n_chk = 0;
    int n_fail = 0;
    string ph = "R2";
    bit rand_ready = 1'b0;

    logic [511:0] q_data[$];
    logic [63:0]  q_keep[$];
    logic         q_last[$];

    logic [511:0] bd = '0;
    logic [7:0]   bsop = '0;
    logic [7:0]   beop = '0;
    logic [23:0]  bemp = '0;
    int           sp = 0;

    task automatic chk(input string req, input bit ok, input string detail);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s", req, detail);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic logic [7:0] pbyte(input int id, input int k);
        return 8'((id * 29) + (k * 3) + 7);
    endfunction

    // Drive the pending beat and wait for acceptance; returns cycles taken.
    task automatic push_beat(output int cyc);
        bit rdy;
        @(negedge clk);
        s_valid = 1'b1; s_data = bd; s_sop = bsop; s_eop = beop; s_empty = bemp;
        cyc = 0;
        forever begin
            #3;
            rdy = s_ready;
            cyc++;
            @(negedge clk);
            if (rdy) break;
        end
        s_valid = 1'b0;
        bd = '0; bsop = '0; beop = '0; bemp = '0; sp = 0;
    endtask

    // Queue expected output beats, then pack the packet into input segments.
    task automatic send_pkt(input int len, input bit tight, input int id);
        int nseg, nb, k, cyc;
        nb = (len + 63) / 64;
        for (int b = 0; b < nb; b++) begin
            logic [511:0] d;
            logic [63:0]  kp;
            d = '0; kp = '0;
            for (int j = 0; j < 64; j++) begin
                if (b * 64 + j < len) begin
                    d[j*8 +: 8] = pbyte(id, b * 64 + j);
                    kp[j] = 1'b1;
                end
            end
            q_data.push_back(d); q_keep.push_back(kp); q_last.push_back(b == nb - 1);
        end
        if (sp > 0 && (!tight || sp == SEGS)) push_beat(cyc);
        nseg = (len + 7) / 8;
        k = 0;
        for (int s = 0; s < nseg; s++) begin
            if (sp == SEGS) push_beat(cyc);
            if (s == 0) bsop[sp] = 1'b1;
            for (int j = 0; j < 8; j++) begin
                if (k < len) bd[(sp*8 + j)*8 +: 8] = pbyte(id, k);
                k++;
            end
            if (s == nseg - 1) begin
                beop[sp] = 1'b1;
                bemp[sp*3 +: 3] = 3'(nseg * 8 - len);
            end
            sp++;
        end
    endtask

    task automatic drain();
        int cyc;
        if (sp > 0) push_beat(cyc);
        while (q_data.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Output ready pattern: constant high or random.
    initial begin
        forever begin
            @(negedge clk);
            m_ready = rand_ready ? (($urandom % 10) < 6) : 1'b1;
        end
    end

    // Monitor: stall stability, handshake rule and scoreboard compare.
    initial begin
        logic [511:0] pd;
        logic [63:0]  pk;
        logic         pl;
        bit           stalled;
        stalled = 1'b0; pd = '0; pk = '0; pl = 1'b0;
        forever begin
            @(negedge clk);
            #3;
            if (rst_n) begin
                if (stalled)
                    chk("R8", m_valid && m_data == pd && m_keep == pk && m_last == pl,
                        $sformatf("stall hold actual v=%0b keep=%h expected v=1 keep=%h", m_valid, m_keep, pk));
                if (s_valid && s_ready)
                    chk("R9", !m_valid || m_ready,
                        $sformatf("input taken actual m_valid=%0b m_ready=%0b expected accept", m_valid, m_ready));
                if (m_valid && m_ready) begin
                    if (q_data.size() == 0) begin
                        chk("R6", 1'b0, "unexpected beat actual=extra expected=none");
                    end else begin
                        logic [511:0] ed, mask;
                        logic [63:0]  ek;
                        logic         el;
                        ed = q_data.pop_front(); ek = q_keep.pop_front(); el = q_last.pop_front();
                        chk(ph, m_data == ed, $sformatf("data actual=%h expected=%h", m_data, ed));
                        chk("R5", m_keep == ek, $sformatf("keep actual=%h expected=%h", m_keep, ek));
                        chk("R6", m_last == el, $sformatf("last actual=%0b expected=%0b", m_last, el));
                        mask = '0;
                        for (int b = 0; b < 64; b++) if (!m_keep[b]) mask[b*8 +: 8] = 8'hFF;
                        chk("R10", (m_data & mask) == '0, $sformatf("dead lanes actual=%h expected=0", m_data & mask));
                    end
                end
                stalled = m_valid && !m_ready;
                pd = m_data; pk = m_keep; pl = m_last;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        int cyc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        chk("R1", !m_valid && !s_ready,
            $sformatf("reset actual m_valid=%0b s_ready=%0b expected 0 0", m_valid, s_ready));

        // R2: every packet starts in segment 0.
        ph = "R2";
        send_pkt(64, 0, 1); send_pkt(128, 0, 2); send_pkt(100, 0, 3);
        send_pkt(8, 0, 4);  send_pkt(1, 0, 5);   send_pkt(200, 0, 6);
        drain();

        // R3: offset starts continuing across beats.
        ph = "R3";
        send_pkt(24, 0, 10); send_pkt(90, 1, 11); send_pkt(13, 1, 12);
        send_pkt(70, 1, 13); send_pkt(150, 1, 14);
        drain();

        // R7: 8-byte packet then 120 bytes from segment 1 leaves a 56-byte tail.
        ph = "R7";
        send_pkt(8, 0, 20); send_pkt(120, 1, 21);
        drain();

        // R4: two short packets sharing one beat need two output cycles.
        ph = "R4";
        send_pkt(10, 0, 30); send_pkt(20, 1, 31);
        push_beat(cyc);
        chk("R4", cyc == 2, $sformatf("split beat cycles actual=%0d expected=2", cyc));
        drain();

        // R8: random packing under random backpressure.
        ph = "R8";
        rand_ready = 1'b1;
        for (int i = 0; i < 150; i++)
            send_pkt(1 + ($urandom % 200), 1'($urandom % 2), 100 + i);
        drain();
        rand_ready = 1'b0;

        report();
        $finish;
    end
endmodule